// File: doc/BRIEF.md
# Ring-Oscillator Entropy Sampler FIFO

This block is the front end of a random-number unit. It receives a 128-bit vector of ring-oscillator sample bits that are already synchronized to the clock. It turns them into 64-bit words and stores those words in a 64-word FIFO. A control port sets the operating mode and the oscillator group. A register-style read port pops one word per request.

There are three producing modes. In the raw mode, one group of eight oscillators is sampled in parallel for eight cycles, and those samples are packed into each word. The deterministic mode runs a fixed-seed LFSR stand-in for a hash conditioner, which gives a reproducible sequence after every clear. The conditioned mode runs the same LFSR with oscillator bits folded into it. The deterministic and conditioned modes each produce one word per 81-cycle period. In every mode the producer keeps running until the FIFO is full, and it starts again as soon as a word is popped.

Top module: `ro_entropy_fifo`

## Requirements
- R1: After reset, `level_o` is 0, `pop_data_o` is 0 and `underflow_o` is 0. While `cfg_run` is stored as 0, no word is produced.
- R2: Raw mode is selected when the stored run, entropy and raw bits are all 1. The first word reaches the FIFO on the 8th rising edge after the edge that takes the control write, and each further word follows 8 edges later.
- R3: Bit 8*k+i of a raw word is oscillator i of the selected group as sampled on gather cycle k (k = 0..7). Cycle 0 fills bits 7:0.
- R4: A group select g (0..15) picks oscillators 8*g to 8*g+7, that is, bits 8*g+7:8*g of `ro_sample_i`.
- R5: When a control write changes the stored entropy bit from 0 to 1, the first gathered byte after that write reads as zero. A control write that leaves the entropy bit at 1 does not zero any byte.
- R6: Any control write discards a partially gathered word, and the next word starts again from cycle 0.
- R7: Deterministic mode is selected by run=1 with entropy=0. It pushes one word every 81 edges. Word n after a clear is step applied n times to the seed 64'h0123456789ABCDEF. One step shifts left by one bit and XORs in 64'h1B when the bit shifted out was 1.
- R8: Conditioned mode is selected by run=1, entropy=1 and raw=0. It pushes its first word on the 81st edge after the control write.
- R9: The FIFO holds at most 64 words. A full FIFO stalls the producer. A pop on a full FIFO in raw mode refills it 8 edges after the pop edge.
- R10: A pop on a non-empty FIFO presents the oldest word on `pop_data_o` after the pop edge, so words come out in the order they were produced.
- R11: A pop on an empty FIFO returns zero and sets `underflow_o`. The flag stays set until a clearing control write.
- R12: A control write with `cfg_clear`=1 empties the FIFO, clears `underflow_o`, clears all mode bits and reseeds the LFSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ro_sample_i | input | 128 | Synchronized oscillator sample bits |
| cfg_we | input | 1 | Control write strobe |
| cfg_clear | input | 1 | With `cfg_we`: flush the FIFO, disable the unit and reseed |
| cfg_run | input | 1 | Unit enable |
| cfg_ent | input | 1 | Entropy source enable |
| cfg_raw | input | 1 | Expose raw samples instead of the conditioner |
| cfg_group | input | 4 | Oscillator group select |
| pop_i | input | 1 | Pop one word |
| pop_data_o | output | 64 | Word returned by the last pop |
| level_o | output | 7 | Number of words in the FIFO |
| underflow_o | output | 1 | Sticky flag for a pop on an empty FIFO |

## Verification
Each result is due a fixed number of edges after its stimulus, counted from the edge that takes the control write:
- a raw word lands on the 8th edge after that write;
- a deterministic or conditioned word lands on the 81st edge;
- pop data is registered, so it appears right after the pop edge;
- a refill after a pop on a full FIFO completes 8 edges later.

The bench changes inputs and reads outputs on falling edges only. For each of these results it checks that the level is unchanged one edge before the due edge and has moved at the due edge. Every bit of each raw word is predicted from the oscillator pattern the bench drove on each gather cycle.

// File: rtl/ro_ent_pkg.sv
package ro_ent_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_DET  = 2'd1,
      MODE_COND = 2'd2,
      MODE_RAW  = 2'd3
   } ro_mode_e;

   function automatic ro_mode_e decode_mode(input logic run, input logic ent, input logic raw);
      ro_mode_e m;
      if (!run)      m = MODE_IDLE;
      else if (!ent) m = MODE_DET;
      else if (raw)  m = MODE_RAW;
      else           m = MODE_COND;
      return m;
   endfunction

endpackage

// File: rtl/ro_group_sel.sv
module ro_group_sel #(
   parameter int N_OSC = 128,
   parameter int GRP_W = 8
) (
   input  logic [N_OSC-1:0]                 osc_i,
   input  logic [$clog2(N_OSC/GRP_W)-1:0]   sel_i,
   output logic [GRP_W-1:0]                 bits_o
);
   localparam int N_GRP = N_OSC / GRP_W;

   if (N_OSC % GRP_W != 0) begin : g_bad_split
      $error("ro_group_sel: N_OSC must be a multiple of GRP_W");
   end
   if (N_GRP < 2) begin : g_bad_count
      $error("ro_group_sel: at least two groups are required");
   end

   logic [GRP_W-1:0] grp_arr [N_GRP];

   for (genvar g = 0; g < N_GRP; g++) begin : g_slice
      assign grp_arr[g] = osc_i[g*GRP_W +: GRP_W];
   end

   assign bits_o = grp_arr[sel_i];

endmodule

// File: rtl/ro_raw_packer.sv
module ro_raw_packer #(
   parameter int GRP_W  = 8,
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              active_i,
   input  logic              space_i,
   input  logic [GRP_W-1:0]  sample_i,
   output logic              take_o,
   output logic              push_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int GATHER = WORD_W / GRP_W;
   localparam int PH_W   = $clog2(GATHER);

   if (WORD_W % GRP_W != 0) begin : g_bad_word
      $error("ro_raw_packer: WORD_W must be a multiple of GRP_W");
   end
   if (GATHER < 2) begin : g_bad_gather
      $error("ro_raw_packer: a word must span at least two gather cycles");
   end

   logic [PH_W-1:0]   phase_q;
   logic [WORD_W-1:0] acc_q;
   logic              last;

   assign last   = (phase_q == PH_W'(GATHER - 1));
   // a new word only starts when the FIFO has room, so a started word always lands
   assign take_o = active_i && !restart_i && ((phase_q != '0) || space_i);
   assign push_o = take_o && last;

   always_comb begin
      word_o = acc_q;
      word_o[phase_q*GRP_W +: GRP_W] = sample_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         acc_q   <= '0;
      end else if (restart_i) begin
         phase_q <= '0;
      end else if (take_o) begin
         acc_q   <= word_o;
         phase_q <= last ? '0 : phase_q + 1'b1;
      end
   end

endmodule

// File: rtl/ro_cond_gen.sv
module ro_cond_gen #(
   parameter int              WORD_W = 64,
   parameter int              N_OSC  = 128,
   parameter int              PERIOD = 81,
   parameter logic [WORD_W-1:0] SEED = 64'h0123456789ABCDEF,
   parameter logic [WORD_W-1:0] POLY = 64'h000000000000001B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reseed_i,
   input  logic              restart_i,
   input  logic              active_i,
   input  logic              mix_en_i,
   input  logic              space_i,
   input  logic [N_OSC-1:0]  osc_i,
   output logic              push_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int CNT_W = $clog2(PERIOD);

   if (PERIOD < 2) begin : g_bad_period
      $error("ro_cond_gen: PERIOD must be at least 2");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] state_q;
   logic [WORD_W-1:0] mix_q;
   logic [WORD_W-1:0] fold;
   logic [WORD_W-1:0] pre;
   logic              at_end;

   always_comb begin
      fold = '0;
      for (int b = 0; b < N_OSC; b++) begin
         fold[b % WORD_W] = fold[b % WORD_W] ^ osc_i[b];
      end
   end

   assign pre    = state_q ^ mix_q;
   assign word_o = {pre[WORD_W-2:0], 1'b0} ^ (pre[WORD_W-1] ? POLY : '0);
   assign at_end = (cnt_q == CNT_W'(PERIOD - 1));
   assign push_o = active_i && !restart_i && !reseed_i && at_end && space_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         state_q <= SEED;
         mix_q   <= '0;
      end else if (reseed_i) begin
         cnt_q   <= '0;
         state_q <= SEED;
         mix_q   <= '0;
      end else if (restart_i) begin
         cnt_q   <= '0;
         mix_q   <= '0;
      end else if (active_i) begin
         if (push_o) begin
            state_q <= word_o;
            cnt_q   <= '0;
            mix_q   <= '0;
         end else begin
            if (!at_end) cnt_q <= cnt_q + 1'b1;
            if (mix_en_i) mix_q <= mix_q ^ fold;
         end
      end
   end

endmodule

// File: rtl/ro_word_fifo.sv
module ro_word_fifo #(
   parameter int WORD_W = 64,
   parameter int DEPTH  = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush_i,
   input  logic                     push_i,
   input  logic [WORD_W-1:0]        push_data_i,
   input  logic                     pop_i,
   output logic [WORD_W-1:0]        pop_data_o,
   output logic [$clog2(DEPTH):0]   level_o,
   output logic                     full_o,
   output logic                     underflow_o
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("ro_word_fifo: DEPTH must be a power of two");
   end

   logic [WORD_W-1:0] mem_q [DEPTH];
   logic [AW-1:0]     wr_q, rd_q;
   logic [AW:0]       cnt_q;
   logic              empty, do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full_o  = (cnt_q == (AW+1)'(DEPTH));
   assign do_push = push_i && !full_o && !flush_i;
   assign do_pop  = pop_i && !empty && !flush_i;
   assign level_o = cnt_q;

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wr_q] <= push_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q        <= '0;
         rd_q        <= '0;
         cnt_q       <= '0;
         pop_data_o  <= '0;
         underflow_o <= 1'b0;
      end else if (flush_i) begin
         wr_q        <= '0;
         rd_q        <= '0;
         cnt_q       <= '0;
         pop_data_o  <= '0;
         underflow_o <= 1'b0;
      end else begin
         if (do_push) wr_q <= wr_q + 1'b1;
         if (do_pop) begin
            rd_q       <= rd_q + 1'b1;
            pop_data_o <= mem_q[rd_q];
         end else if (pop_i) begin
            pop_data_o  <= '0;
            underflow_o <= 1'b1;
         end
         cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end

endmodule

// File: rtl/ro_entropy_fifo.sv
module ro_entropy_fifo
   import ro_ent_pkg::*;
#(
   parameter int                N_OSC       = 128,
   parameter int                GRP_W       = 8,
   parameter int                WORD_W      = 64,
   parameter int                DEPTH       = 64,
   parameter int                COND_PERIOD = 81,
   parameter logic [WORD_W-1:0] SEED        = 64'h0123456789ABCDEF,
   parameter logic [WORD_W-1:0] POLY        = 64'h000000000000001B
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [N_OSC-1:0]                 ro_sample_i,
   input  logic                             cfg_we,
   input  logic                             cfg_clear,
   input  logic                             cfg_run,
   input  logic                             cfg_ent,
   input  logic                             cfg_raw,
   input  logic [$clog2(N_OSC/GRP_W)-1:0]   cfg_group,
   input  logic                             pop_i,
   output logic [WORD_W-1:0]                pop_data_o,
   output logic [$clog2(DEPTH):0]           level_o,
   output logic                             underflow_o
);
   localparam int GSEL_W = $clog2(N_OSC / GRP_W);

   logic              run_q, ent_q, raw_q, first_q;
   logic [GSEL_W-1:0] grp_q;
   ro_mode_e          mode;
   logic              clear_wr;
   logic [GRP_W-1:0]  grp_bits, raw_sample;
   logic              full, raw_take, raw_push, gen_push;
   logic [WORD_W-1:0] raw_word, gen_word, push_word;

   assign clear_wr = cfg_we && cfg_clear;
   assign mode     = decode_mode(run_q, ent_q, raw_q);

   // control register; first_q marks the first gather after entropy comes on
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         ent_q   <= 1'b0;
         raw_q   <= 1'b0;
         grp_q   <= '0;
         first_q <= 1'b0;
      end else if (cfg_we) begin
         run_q   <= cfg_run && !cfg_clear;
         ent_q   <= cfg_ent && !cfg_clear;
         raw_q   <= cfg_raw && !cfg_clear;
         grp_q   <= cfg_clear ? '0 : cfg_group;
         first_q <= cfg_clear ? 1'b0 : (first_q || (cfg_ent && !ent_q));
      end else if (raw_take) begin
         first_q <= 1'b0;
      end
   end

   ro_group_sel #(.N_OSC(N_OSC), .GRP_W(GRP_W)) u_sel (
      .osc_i  (ro_sample_i),
      .sel_i  (grp_q),
      .bits_o (grp_bits)
   );

   assign raw_sample = first_q ? '0 : grp_bits;

   ro_raw_packer #(.GRP_W(GRP_W), .WORD_W(WORD_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (cfg_we),
      .active_i  (mode == MODE_RAW),
      .space_i   (!full),
      .sample_i  (raw_sample),
      .take_o    (raw_take),
      .push_o    (raw_push),
      .word_o    (raw_word)
   );

   ro_cond_gen #(
      .WORD_W (WORD_W),
      .N_OSC  (N_OSC),
      .PERIOD (COND_PERIOD),
      .SEED   (SEED),
      .POLY   (POLY)
   ) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .reseed_i  (clear_wr),
      .restart_i (cfg_we),
      .active_i  ((mode == MODE_DET) || (mode == MODE_COND)),
      .mix_en_i  (mode == MODE_COND),
      .space_i   (!full),
      .osc_i     (ro_sample_i),
      .push_o    (gen_push),
      .word_o    (gen_word)
   );

   assign push_word = raw_push ? raw_word : gen_word;

   ro_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (clear_wr),
      .push_i      (raw_push || gen_push),
      .push_data_i (push_word),
      .pop_i       (pop_i),
      .pop_data_o  (pop_data_o),
      .level_o     (level_o),
      .full_o      (full),
      .underflow_o (underflow_o)
   );

endmodule

// File: rtl/ro_entropy_fifo_chk.sv
module ro_entropy_fifo_chk #(
   parameter int WORD_W = 64,
   parameter int DEPTH  = 64
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_we,
   input logic                    cfg_clear,
   input logic                    pop_i,
   input logic                    run_q,
   input logic [$clog2(DEPTH):0]  level_o,
   input logic                    underflow_o,
   input logic [WORD_W-1:0]       pop_data_o
);
   localparam int LVL_W = $clog2(DEPTH) + 1;

   assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      level_o <= LVL_W'(DEPTH));

   assert_clear_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_clear) |=> (level_o == '0 && !underflow_o));

   assert_underflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow_o && !(cfg_we && cfg_clear)) |=> underflow_o);

   assert_empty_pop_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && level_o == '0 && !(cfg_we && cfg_clear)) |=> (pop_data_o == '0 && underflow_o));

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !pop_i && !cfg_we) |=> $stable(level_o));

   assert_level_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_clear) |=> (level_o == $past(level_o) ||
                                  level_o == $past(level_o) + 1'b1 ||
                                  level_o + 1'b1 == $past(level_o)));

endmodule

bind ro_entropy_fifo ro_entropy_fifo_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_clear   (cfg_clear),
   .pop_i       (pop_i),
   .run_q       (run_q),
   .level_o     (level_o),
   .underflow_o (underflow_o),
   .pop_data_o  (pop_data_o)
);

// File: tb/ro_entropy_fifo_tb.sv
module ro_entropy_fifo_tb;
   localparam int          CLK_PERIOD = 10;
   localparam logic [63:0] T_SEED = 64'h0123456789ABCDEF;
   localparam logic [63:0] T_POLY = 64'h000000000000001B;
   localparam int          NVEC   = 4;
   localparam logic [3:0]  TAB_GRP  [NVEC] = '{4'd0, 4'd5, 4'd10, 4'd15};
   localparam logic [7:0]  TAB_SALT [NVEC] = '{8'h11, 8'h42, 8'h97, 8'hE3};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] ro_sample_i = '0;
   logic         cfg_we = 1'b0, cfg_clear = 1'b0, cfg_run = 1'b0, cfg_ent = 1'b0, cfg_raw = 1'b0;
   logic [3:0]   cfg_group = '0;
   logic         pop_i = 1'b0;
   logic [63:0]  pop_data_o;
   logic [6:0]   level_o;
   logic         underflow_o;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ro_entropy_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .ro_sample_i(ro_sample_i),
      .cfg_we(cfg_we), .cfg_clear(cfg_clear), .cfg_run(cfg_run), .cfg_ent(cfg_ent),
      .cfg_raw(cfg_raw), .cfg_group(cfg_group), .pop_i(pop_i),
      .pop_data_o(pop_data_o), .level_o(level_o), .underflow_o(underflow_o)
   );

   function automatic logic [7:0] pat(input int k, input int j, input logic [7:0] salt);
      return 8'(k*29 + j*53 + int'(salt));
   endfunction

   function automatic logic [127:0] vec(input int k, input logic [7:0] salt);
      logic [127:0] v;
      for (int j = 0; j < 16; j++) v[8*j +: 8] = pat(k, j, salt);
      return v;
   endfunction

   function automatic logic [63:0] exp_word(input int base, input int grp, input logic [7:0] salt,
                                            input bit zero_first);
      logic [63:0] w;
      for (int b = 0; b < 8; b++) w[8*b +: 8] = (zero_first && b == 0) ? 8'h00 : pat(base + b, grp, salt);
      return w;
   endfunction

   function automatic logic [63:0] step(input logic [63:0] s);
      return {s[62:0], 1'b0} ^ (s[63] ? T_POLY : 64'h0);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ctl(input bit clr, input bit run, input bit ent, input bit raw, input logic [3:0] grp);
      cfg_clear = clr; cfg_run = run; cfg_ent = ent; cfg_raw = raw; cfg_group = grp;
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; cfg_clear = 1'b0;
   endtask

   task automatic pop_one(output logic [63:0] w);
      pop_i = 1'b1;
      @(negedge clk);
      pop_i = 1'b0;
      w = pop_data_o;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [63:0] w, e, w1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state and idle
      chk(level_o == 7'd0, "R1 level after reset", 64'(level_o), 64'd0);
      chk(pop_data_o == 64'd0, "R1 data after reset", pop_data_o, 64'd0);
      chk(underflow_o == 1'b0, "R1 underflow after reset", 64'(underflow_o), 64'd0);
      repeat (100) @(negedge clk);
      chk(level_o == 7'd0, "R1 idle produces nothing", 64'(level_o), 64'd0);

      // table walk: R2 R3 R4 R5 R10 raw packing over groups
      for (int t = 0; t < NVEC; t++) begin
         ctl(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
         ctl(1'b0, 1'b1, 1'b1, 1'b1, TAB_GRP[t]);
         for (int k = 0; k < 16; k++) begin
            ro_sample_i = vec(k, TAB_SALT[t]);
            @(negedge clk);
            if (k == 6) chk(level_o == 7'd0, "R2 no word before 8th edge", 64'(level_o), 64'd0);
            if (k == 7) chk(level_o == 7'd1, "R2 word on 8th edge", 64'(level_o), 64'd1);
         end
         chk(level_o == 7'd2, "R2 second word 8 edges later", 64'(level_o), 64'd2);
         pop_one(w);
         e = exp_word(0, int'(TAB_GRP[t]), TAB_SALT[t], 1'b1);
         chk(w == e, "R5 R4 first word zero byte then group bytes", w, e);
         pop_one(w);
         e = exp_word(8, int'(TAB_GRP[t]), TAB_SALT[t], 1'b0);
         chk(w == e, "R3 R10 second word packing and order", w, e);
      end

      // R6 mid-word group change restarts gather, no zero byte
      ctl(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
      ctl(1'b0, 1'b1, 1'b1, 1'b1, 4'd3);
      for (int k = 0; k < 3; k++) begin
         ro_sample_i = vec(k, 8'h5A);
         @(negedge clk);
      end
      ctl(1'b0, 1'b1, 1'b1, 1'b1, 4'd5);
      for (int k = 0; k < 8; k++) begin
         ro_sample_i = vec(k, 8'h77);
         @(negedge clk);
         if (k == 6) chk(level_o == 7'd0, "R6 partial word discarded", 64'(level_o), 64'd0);
      end
      chk(level_o == 7'd1, "R6 restarted word lands", 64'(level_o), 64'd1);
      pop_one(w);
      e = exp_word(0, 5, 8'h77, 1'b0);
      chk(w == e, "R6 R5 restarted word content", w, e);

      // R7 deterministic timing and sequence
      ctl(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
      ctl(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
      repeat (80) @(negedge clk);
      chk(level_o == 7'd0, "R7 none before 81st edge", 64'(level_o), 64'd0);
      @(negedge clk);
      chk(level_o == 7'd1, "R7 word on 81st edge", 64'(level_o), 64'd1);
      repeat (81) @(negedge clk);
      chk(level_o == 7'd2, "R7 second word 81 later", 64'(level_o), 64'd2);
      pop_one(w);
      e = step(T_SEED);
      chk(w == e, "R7 first deterministic word", w, e);
      pop_one(w);
      e = step(step(T_SEED));
      chk(w == e, "R7 second deterministic word", w, e);
      ctl(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
      ctl(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
      repeat (81) @(negedge clk);
      pop_one(w);
      e = step(T_SEED);
      chk(w == e, "R7 R12 reproducible after clear", w, e);

      // R8 conditioned timing
      ctl(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
      ctl(1'b0, 1'b1, 1'b1, 1'b0, 4'd0);
      repeat (80) @(negedge clk);
      chk(level_o == 7'd0, "R8 none before 81st edge", 64'(level_o), 64'd0);
      @(negedge clk);
      chk(level_o == 7'd1, "R8 word on 81st edge", 64'(level_o), 64'd1);

      // R9 fill, stall, refill
      ctl(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
      ctl(1'b0, 1'b1, 1'b1, 1'b1, 4'd2);
      repeat (530) @(negedge clk);
      chk(level_o == 7'd64, "R9 full at 64", 64'(level_o), 64'd64);
      repeat (20) @(negedge clk);
      chk(level_o == 7'd64, "R9 stalls when full", 64'(level_o), 64'd64);
      pop_one(w1);
      chk(level_o == 7'd63, "R9 pop lowers level", 64'(level_o), 64'd63);
      repeat (7) @(negedge clk);
      chk(level_o == 7'd63, "R9 refill not before 8 edges", 64'(level_o), 64'd63);
      @(negedge clk);
      chk(level_o == 7'd64, "R9 refilled after 8 edges", 64'(level_o), 64'd64);

      // R12 clear empties and disables
      ctl(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
      chk(level_o == 7'd0, "R12 clear empties FIFO", 64'(level_o), 64'd0);
      repeat (50) @(negedge clk);
      chk(level_o == 7'd0, "R12 clear disables unit", 64'(level_o), 64'd0);

      // R11 underflow
      pop_one(w);
      chk(w == 64'd0, "R11 empty pop returns zero", w, 64'd0);
      chk(underflow_o == 1'b1, "R11 underflow set", 64'(underflow_o), 64'd1);
      repeat (5) @(negedge clk);
      chk(underflow_o == 1'b1, "R11 underflow sticky", 64'(underflow_o), 64'd1);
      ctl(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
      chk(underflow_o == 1'b0, "R12 clear drops underflow", 64'(underflow_o), 64'd0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule